// File: doc/BRIEF.md
# Prescaled Watchdog Counter

This block is a watchdog built around a 16-bit up-counter. Software programs a timeout limit, picks one of three tick-enable inputs as the count source, and picks a prescale ratio that is a power of four from 1 to 1024. It then sets the enable bit. The counter advances once for every N qualifying ticks, where N is the prescale ratio. When the counter equals the limit while the block is enabled, a reset request pulse of fixed length is driven out. The counter then stays frozen until software clears the enable bit.

All logic sits in one system clock domain. The three tick inputs are single-cycle strobes from that domain. Access is through a simple synchronous register bus. A write takes effect on the clock edge on which it is presented, and read data is combinational from the address. The expected sequence is: clear enable, program the limit, control and counter registers, then set enable again.

Top module: `wdog_prescaled`

## Requirements
- R1: After reset the limit, counter, control and enable registers all read zero and `wdt_rst_o` is low.
- R2: Register offsets are decoded from `bus_addr[3:2]`: 0x0 is the 16-bit limit, 0x4 is enable, 0x8 is the counter and 0xC is control. Control keeps bits [5:0] and reads zero in bits [15:6].
- R3: The enable register holds only bit 0. Bits [15:1] of a read at 0x4 are zero.
- R4: A write to the counter register loads the written value, so writing 0 clears the count.
- R5: Control bits [2:0] choose the count source. Bit 0 selects `src_tick[0]`, bit 1 selects `src_tick[1]` and bit 2 selects `src_tick[2]`. The lowest set bit wins. With no bit set, the counter never advances.
- R6: Control bits [5:3] hold a prescale code c. Codes 0 to 5 divide the selected ticks by 4^c, and codes 6 and 7 divide by 1024.
- R7: Clearing the enable bit resets the prescaler phase. Ticks that did not complete a prescale period before the disable are not carried into the next enabled run.
- R8: When the block is enabled and the counter equals the limit, `wdt_rst_o` rises on the following clock edge and stays high for exactly 16 cycles. The counter stays at the limit.
- R9: Clearing the enable bit releases the frozen state. After the counter is rewritten and the block is enabled again, counting resumes.
- R10: While the enable bit is 0, ticks do not change the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick | input | 3 | Tick-enable strobes of the three count sources |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| wdt_rst_o | output | 1 | Reset request pulse |

## Verification
The bench sweeps every prescale code, including the two codes above 5, and every source mask, including the empty mask and masks with several bits set. A wrong priority or a missing clamp on the code shows up as a counter value that differs from the bench's count of selected ticks divided by the ratio. A separate sequence stops a prescale period part way, disables the block, re-enables it and finishes the period. A prescaler that kept its phase across the disable would then report one step where none is due. The trip sequence checks the exact edge on which the reset pulse starts and its length of 16 cycles. An off-by-one compare would shift that start, and a counter that kept running past the limit would read back above it. The sequence also checks that the frozen state is released once enable is cleared.

// File: rtl/wdog_prescaled.sv
module wdog_prescaled #(
  parameter int CW    = 16,
  parameter int PULSE = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    src_tick,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [3:0]    bus_addr,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          wdt_rst_o
);
  localparam int PW  = 10;
  localparam int PLW = $clog2(PULSE + 1);

  logic [CW-1:0]  lim_q, cnt_q;
  logic [5:0]     ctl_q;
  logic           en_q, trip_q;
  logic [PW-1:0]  pre_q, pre_lim;
  logic [PLW-1:0] pls_q;
  logic [2:0]     code_c;
  logic           tick_sel;

  wire wr     = bus_sel & bus_we;
  wire wr_lim = wr && bus_addr[3:2] == 2'd0;
  wire wr_en  = wr && bus_addr[3:2] == 2'd1;
  wire wr_cnt = wr && bus_addr[3:2] == 2'd2;
  wire wr_ctl = wr && bus_addr[3:2] == 2'd3;

  always_comb begin
    if (ctl_q[0])      tick_sel = src_tick[0];
    else if (ctl_q[1]) tick_sel = src_tick[1];
    else if (ctl_q[2]) tick_sel = src_tick[2];
    else               tick_sel = 1'b0;
  end

  assign code_c  = (ctl_q[5:3] > 3'd5) ? 3'd5 : ctl_q[5:3];
  assign pre_lim = PW'((32'd1 << (32'(code_c) * 2)) - 32'd1);

  wire match = en_q & ~trip_q & (cnt_q == lim_q);
  wire adv   = en_q & ~trip_q & ~match & tick_sel;
  wire step  = adv & (pre_q == pre_lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      en_q   <= 1'b0;
      trip_q <= 1'b0;
      pre_q  <= '0;
      pls_q  <= '0;
    end else begin
      if (wr_lim) lim_q <= bus_wdata;
      if (wr_ctl) ctl_q <= bus_wdata[5:0];
      if (wr_en)  en_q  <= bus_wdata[0];

      if (!en_q)    pre_q <= '0;
      else if (adv) pre_q <= step ? '0 : pre_q + 1'b1;

      if (wr_cnt)    cnt_q <= bus_wdata;
      else if (step) cnt_q <= cnt_q + 1'b1;

      if (!en_q)      trip_q <= 1'b0;
      else if (match) trip_q <= 1'b1;

      if (match)              pls_q <= PLW'(PULSE);
      else if (pls_q != '0)   pls_q <= pls_q - 1'b1;
    end
  end

  assign wdt_rst_o = (pls_q != '0);

  always_comb begin
    case (bus_addr[3:2])
      2'd0:    bus_rdata = lim_q;
      2'd1:    bus_rdata = {{(CW-1){1'b0}}, en_q};
      2'd2:    bus_rdata = cnt_q;
      default: bus_rdata = {{(CW-6){1'b0}}, ctl_q};
    endcase
  end
endmodule

module wdog_prescaled_chk #(
  parameter int CW    = 16,
  parameter int PULSE = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic [CW-1:0] cnt_q,
  input logic [CW-1:0] lim_q,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [3:0]    bus_addr,
  input logic [CW-1:0] bus_rdata,
  input logic          wdt_rst_o
);
  logic [7:0] hi_len;
  wire cnt_wr = bus_sel & bus_we & (bus_addr[3:2] == 2'd2);
  wire any_wr = bus_sel & bus_we;

  always_ff @(posedge clk) begin
    if (!rst_n)         hi_len <= '0;
    else if (wdt_rst_o) hi_len <= hi_len + 8'd1;
    else                hi_len <= '0;
  end

  p_frozen_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !cnt_wr) |=> $stable(cnt_q));

  p_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !cnt_wr) |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  p_hold_at_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && cnt_q == lim_q && !any_wr) |=> $stable(cnt_q));

  p_pulse_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst_o |-> hi_len < 8'(PULSE));

  p_pulse_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdt_rst_o) |-> $past(hi_len) == 8'(PULSE - 1));

  p_en_upper_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr[3:2] == 2'd1) |-> bus_rdata[CW-1:1] == '0);
endmodule

bind wdog_prescaled wdog_prescaled_chk #(.CW(CW), .PULSE(PULSE)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .cnt_q(cnt_q), .lim_q(lim_q),
  .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o)
);

// File: tb/wdog_prescaled_tb_top.sv
`timescale 1ns/1ps
module wdog_prescaled_tb_top;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  src_tick = '0;
  logic        bus_sel = 0, bus_we = 0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic        wdt_rst_o;
  int checks = 0, errors = 0;
  bit done = 0;

  wdog_prescaled dut_i (.clk(clk), .rst_n(rst_n), .src_tick(src_tick),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdt_rst_o(wdt_rst_o));

  always #5 clk = ~clk;

  function automatic int ratio(input int code);
    return (code >= 5) ? 1024 : (1 << (2 * code));
  endfunction

  function automatic bit picked(input logic [2:0] mask, input logic [2:0] t);
    if (mask[0]) return t[0];
    if (mask[1]) return t[1];
    if (mask[2]) return t[2];
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic run_ticks(input logic [2:0] mask, input int ncyc, input logic [2:0] fixed,
                           input bit rnd, output int n);
    n = 0;
    for (int i = 0; i < ncyc; i++) begin
      src_tick = rnd ? 3'($urandom % 8) : fixed;
      if (picked(mask, src_tick)) n++;
      @(negedge clk);
    end
    src_tick = '0;
  endtask

  task automatic prog(input int code, input logic [2:0] mask, input logic [15:0] lim);
    wr(4'h4, 16'h0);
    wr(4'hC, 16'((code << 3) | mask));
    wr(4'h0, lim);
    wr(4'h8, 16'h0);
    wr(4'h4, 16'h1);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: run hung");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    int n, first, highs;
    void'($urandom(32'd4242));
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(4'h0, d); check("R1 limit", d, 0);
    rd(4'h4, d); check("R1 enable", d, 0);
    rd(4'h8, d); check("R1 counter", d, 0);
    rd(4'hC, d); check("R1 control", d, 0);
    check("R1 rst_o", wdt_rst_o, 0);

    // R2 / R3 map and read-back
    wr(4'h0, 16'hBEEF); rd(4'h0, d); check("R2 limit", d, 16'hBEEF);
    wr(4'hC, 16'hFFFF); rd(4'hC, d); check("R2 control", d, 16'h003F);
    wr(4'h4, 16'hFFFF); rd(4'h4, d); check("R3 enable", d, 16'h0001);
    wr(4'h4, 16'h0000);

    // R4 / R10 write loads counter, disabled ignores ticks
    wr(4'hC, 16'h0001);
    wr(4'h8, 16'h0007); rd(4'h8, d); check("R4 load", d, 7);
    run_ticks(3'b001, 20, 3'b111, 0, n);
    rd(4'h8, d); check("R10 disabled hold", d, 7);
    wr(4'h8, 16'h0000); rd(4'h8, d); check("R4 clear", d, 0);

    // R5 / R6 random sweep
    for (int it = 0; it < 24; it++) begin
      int code; logic [2:0] mask; int ncyc;
      code = (it < 8) ? it : int'($urandom % 8);
      mask = 3'($urandom % 8);
      ncyc = 50 + int'($urandom % 400);
      if (code < 2) ncyc = 60;
      prog(code, mask, 16'hFFFF);
      run_ticks(mask, ncyc, 3'b000, 1, n);
      wr(4'h4, 16'h0);
      rd(4'h8, d); check("R5/R6 random", d, 32'(n / ratio(code)));
    end

    // R5 priority and empty mask
    prog(0, 3'b110, 16'hFFFF);
    run_ticks(3'b110, 10, 3'b100, 0, n);
    wr(4'h4, 16'h0); rd(4'h8, d); check("R5 bit1 over bit2", d, 0);
    prog(0, 3'b000, 16'hFFFF);
    run_ticks(3'b000, 10, 3'b111, 0, n);
    wr(4'h4, 16'h0); rd(4'h8, d); check("R5 no source", d, 0);

    // R6 divide by 1024 for codes 5 and 7
    prog(5, 3'b100, 16'hFFFF);
    run_ticks(3'b100, 2100, 3'b100, 0, n);
    wr(4'h4, 16'h0); rd(4'h8, d); check("R6 code5", d, 2);
    prog(7, 3'b010, 16'hFFFF);
    run_ticks(3'b010, 1030, 3'b010, 0, n);
    wr(4'h4, 16'h0); rd(4'h8, d); check("R6 code7", d, 1);

    // R7 prescaler phase cleared by disable
    prog(1, 3'b001, 16'hFFFF);
    run_ticks(3'b001, 3, 3'b001, 0, n);
    wr(4'h4, 16'h0);
    wr(4'h4, 16'h1);
    run_ticks(3'b001, 3, 3'b001, 0, n);
    wr(4'h4, 16'h0); rd(4'h8, d); check("R7 phase reset", d, 0);

    // R8 trip timing and pulse length
    prog(0, 3'b001, 16'd5);
    src_tick = 3'b001;
    first = -1; highs = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (wdt_rst_o) begin
        highs++;
        if (first < 0) first = k;
      end
    end
    src_tick = '0;
    check("R8 pulse start", 32'(first), 6);
    check("R8 pulse length", 32'(highs), 16);
    rd(4'h8, d); check("R8 counter held", d, 5);

    // R9 release and resume
    wr(4'h4, 16'h0);
    rd(4'h8, d); check("R9 value after disable", d, 5);
    wr(4'h8, 16'h0);
    wr(4'h4, 16'h1);
    run_ticks(3'b001, 3, 3'b001, 0, n);
    wr(4'h4, 16'h0); rd(4'h8, d); check("R9 resumed", d, 3);
    check("R9 no pulse", wdt_rst_o, 0);

    finish_run();
  end
endmodule